// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It has one transmitter and one receiver, and both use the same frame format setting. The format is picked from five choices: 7 data bits, 7 data bits plus parity, 8 data bits, 8 data bits plus parity, or 9 data bits. Every frame has one low start bit and one high stop bit. A baud tick input runs at sixteen times the bit rate. Each line bit lasts one count of `OSR` ticks.

The receive interrupt and the error flags are raised at fixed sample points, and those points depend on the format. In the two formats that fill nine bit slots before the stop bit (9 data bits, and 8 data bits plus parity), the receive interrupt and the overrun flag are raised at the middle of that ninth slot. In those formats the framing flag becomes valid one bit period later. In every other format, these events wait for the middle of the stop bit. The transmit interrupt is a single-clock pulse raised one clock before the line goes high for the stop bit.

The transmitter states are TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP:
- TX_IDLE moves to TX_START on a load.
- Each of the other states lasts one bit period.
- TX_DATA exits to TX_PAR or TX_STOP after the last data bit.
- TX_STOP returns to TX_IDLE.

The receiver states are RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP:
- RX_IDLE moves to RX_START on a falling line edge.
- RX_START checks the line at half a bit. It goes to RX_DATA if the line is still low, and back to RX_IDLE if it is not.
- RX_DATA exits to RX_PAR or RX_STOP after the last data bit.
- RX_PAR moves to RX_STOP at its middle sample.
- RX_STOP returns to RX_IDLE at its middle sample.

Top module: `uart_mf`

## Requirements
- R1: `fmt` selects the frame layout: 0 = 7 data bits, 1 = 7 data bits + parity, 2 = 8 data bits, 3 = 8 data bits + parity, 4 = 9 data bits, 5..7 = same as 2. The transmitted frame is a low start bit, then the data bits LSB first, then the parity bit if the format has one, then a high stop bit. Each bit lasts 16 baud ticks.
- R2: The parity bit makes the count of ones over the data bits plus the parity bit even when `par_odd` = 0, and odd when `par_odd` = 1. This applies to both transmit and receive.
- R3: `tx_irq` is a one-clock pulse that goes high exactly one clock before `tx_line` rises for the stop bit.
- R4: `tx_load` has no effect while a frame is being sent. `tx_data` bits above the format's data width are not sent.
- R5: A completed frame puts the data bits in `rx_data` (bit 0 first received). The bits above the data width read 0.
- R6: `rx_irq` is a one-clock pulse. It is raised at the middle of the last data bit for format 4, at the middle of the parity bit for format 3, and at the middle of the stop bit for all other formats.
- R7: `err_frame` is set at the middle of the stop bit when the stop bit is sampled low, in every format. In formats 3 and 4 it is still 0 when `rx_irq` pulses.
- R8: `err_parity` is set when the received parity does not match. It is set at the middle of the parity bit in format 3 and at the middle of the stop bit in format 1. It is never set in formats without parity.
- R9: If a frame completes while the previous word has not been read, `rx_data` keeps the old word. `err_overrun` is then set in the same clock as that frame's `rx_irq`.
- R10: The error flags stay set until `rx_read` is pulsed. A read clears all three flags and marks the buffer as read.
- R11: A low pulse that has ended by the half-bit check is not taken as a start bit. It produces no `rx_irq`, and the receiver accepts the next frame normally.
- R12: After reset, `tx_line` is 1, both interrupts and all flags are 0, and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversample tick, OSR per bit |
| fmt | input | 3 | Frame format code |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| tx_data | input | 9 | Word to send |
| tx_load | input | 1 | Start sending `tx_data` (ignored when busy) |
| tx_line | output | 1 | Serial output, idle high |
| tx_irq | output | 1 | Pulse just before the stop bit |
| rx_line | input | 1 | Serial input |
| rx_read | input | 1 | Read strobe; clears buffer-full and flags |
| rx_data | output | 9 | Received word |
| rx_irq | output | 1 | Receive-complete pulse |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Frame lost to an unread buffer |

## Verification
The bench builds the block with the default `OSR` of 16. It drives `baud_tick` on every fourth clock, so one bit lasts 64 clocks and a sweep across all six format codes, both parity senses and edge-case data words fits in a short run. Transmit loads are aligned to a tick, which makes the stop-bit interrupt land on an exact clock that the bench computes from the bit count. Receive event points are checked by which bit slot they fall in and by their offset inside that slot. This is how the early ninth-slot interrupt is told apart from the stop-bit interrupt.

// File: rtl/uart_mf_pkg.sv
package uart_mf_pkg;

    localparam int UMF_DMAX = 9;
    localparam int UMF_IW   = $clog2(UMF_DMAX + 1);

    typedef struct packed {
        logic [UMF_IW-1:0] nbits;   // data bits per frame
        logic              par;     // parity slot present
        logic              early;   // event point is the ninth slot, not the stop bit
    } frame_cfg_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    function automatic frame_cfg_t decode_fmt(input logic [2:0] code);
        frame_cfg_t c;
        case (code)
            3'd0:    c = '{nbits: UMF_IW'(7), par: 1'b0, early: 1'b0};
            3'd1:    c = '{nbits: UMF_IW'(7), par: 1'b1, early: 1'b0};
            3'd3:    c = '{nbits: UMF_IW'(8), par: 1'b1, early: 1'b1};
            3'd4:    c = '{nbits: UMF_IW'(9), par: 1'b0, early: 1'b1};
            default: c = '{nbits: UMF_IW'(8), par: 1'b0, early: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_mf_rx.sv
module uart_mf_rx
    import uart_mf_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line_in,
    input  logic [2:0]          fmt,
    input  logic                par_odd,
    input  logic                rd,
    output logic [UMF_DMAX-1:0] word,
    output logic                irq,
    output logic                fe,
    output logic                pe,
    output logic                oe
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_FULL = CW'(OSR - 1);
    localparam logic [CW-1:0] LAST_HALF = CW'(OSR / 2 - 1);

    rx_state_t           st, nxt;
    logic [CW-1:0]       cnt;
    logic [UMF_IW-1:0]   idx;
    logic [UMF_DMAX-1:0] shreg, word_now;
    frame_cfg_t          cfg;
    logic                podd_q;
    logic                s1, s2, s3;
    logic                fall, mid, last_data, par_bad, done_evt;
    logic                full, pend_pe;

    // two-stage synchronizer plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        fall      = s3 & ~s2;
        mid       = tick && ((st == RX_START) ? (cnt == LAST_HALF) : (cnt == LAST_FULL));
        last_data = (idx == cfg.nbits - UMF_IW'(1));
        word_now  = shreg;
        if (st == RX_DATA) word_now[idx] = s2;
        par_bad   = (^shreg) ^ s2 ^ podd_q;
        done_evt  = cfg.early
                  ? ((st == RX_DATA && mid && last_data && !cfg.par) || (st == RX_PAR && mid))
                  : (st == RX_STOP && mid);
        nxt = st;
        unique case (st)
            RX_IDLE:  if (fall) nxt = RX_START;
            RX_START: if (mid)  nxt = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (mid && last_data) nxt = cfg.par ? RX_PAR : RX_STOP;
            RX_PAR:   if (mid)  nxt = RX_STOP;
            RX_STOP:  if (mid)  nxt = RX_IDLE;
            default:            nxt = RX_IDLE;
        endcase
    end

    // state register and bit timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            cfg    <= decode_fmt(3'd2);
            podd_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == RX_IDLE || mid) cnt <= '0;
            else if (tick)            cnt <= cnt + CW'(1);
            if (st != RX_DATA) idx <= '0;
            else if (mid)      idx <= idx + UMF_IW'(1);
            if (st == RX_IDLE && fall) begin
                cfg    <= decode_fmt(fmt);
                podd_q <= par_odd;
                shreg  <= '0;
            end else if (st == RX_DATA && mid) begin
                shreg[idx] <= s2;
            end
        end
    end

    // buffer, interrupt and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= '0;
            irq     <= 1'b0;
            full    <= 1'b0;
            fe      <= 1'b0;
            pe      <= 1'b0;
            oe      <= 1'b0;
            pend_pe <= 1'b0;
        end else begin
            irq <= done_evt;
            if (rd) begin
                full <= 1'b0;
                fe   <= 1'b0;
                pe   <= 1'b0;
                oe   <= 1'b0;
            end
            if (done_evt) begin
                if (full) oe <= 1'b1;
                else begin
                    word <= word_now;
                    full <= 1'b1;
                end
            end
            if (st == RX_IDLE && fall) pend_pe <= 1'b0;
            if (st == RX_PAR && mid && par_bad) begin
                if (cfg.early) pe <= 1'b1;
                else           pend_pe <= 1'b1;
            end
            if (st == RX_STOP && mid) begin
                if (!s2)     fe <= 1'b1;
                if (pend_pe) pe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_mf_tx.sv
module uart_mf_tx
    import uart_mf_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [2:0]          fmt,
    input  logic                par_odd,
    input  logic [UMF_DMAX-1:0] din,
    input  logic                load,
    output logic                line_out,
    output logic                irq
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_FULL = CW'(OSR - 1);

    tx_state_t           st, nxt;
    logic [CW-1:0]       cnt;
    logic [UMF_IW-1:0]   idx;
    logic [UMF_DMAX-1:0] sh, ld_mask, ld_word;
    frame_cfg_t          cfg, ld_cfg;
    logic                pbit, bit_end, last_data, line_c;

    always_comb begin
        ld_cfg = decode_fmt(fmt);
        for (int i = 0; i < UMF_DMAX; i++) ld_mask[i] = (i < int'(ld_cfg.nbits));
        ld_word   = din & ld_mask;
        bit_end   = tick && (cnt == LAST_FULL);
        last_data = (idx == cfg.nbits - UMF_IW'(1));
        nxt = st;
        unique case (st)
            TX_IDLE:  if (load)    nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && last_data) nxt = cfg.par ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            default:               nxt = TX_IDLE;
        endcase
        unique case (st)
            TX_START: line_c = 1'b0;
            TX_DATA:  line_c = sh[idx];
            TX_PAR:   line_c = pbit;
            default:  line_c = 1'b1;
        endcase
    end

    // state register and bit timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            cfg  <= decode_fmt(3'd2);
            pbit <= 1'b0;
        end else begin
            st <= nxt;
            if (st == TX_IDLE || bit_end) cnt <= '0;
            else if (tick)                cnt <= cnt + CW'(1);
            if (st != TX_DATA) idx <= '0;
            else if (bit_end)  idx <= idx + UMF_IW'(1);
            if (st == TX_IDLE && load) begin
                cfg  <= ld_cfg;
                sh   <= ld_word;
                pbit <= (^ld_word) ^ par_odd;
            end
        end
    end

    // registered line and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_out <= 1'b1;
            irq      <= 1'b0;
        end else begin
            line_out <= line_c;
            irq      <= (st != TX_STOP) && (nxt == TX_STOP);
        end
    end

endmodule

// File: rtl/uart_mf.sv
module uart_mf
    import uart_mf_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic [2:0]          fmt,
    input  logic                par_odd,
    input  logic [UMF_DMAX-1:0] tx_data,
    input  logic                tx_load,
    output logic                tx_line,
    output logic                tx_irq,
    input  logic                rx_line,
    input  logic                rx_read,
    output logic [UMF_DMAX-1:0] rx_data,
    output logic                rx_irq,
    output logic                err_frame,
    output logic                err_parity,
    output logic                err_overrun
);

    uart_mf_tx #(.OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .fmt      (fmt),
        .par_odd  (par_odd),
        .din      (tx_data),
        .load     (tx_load),
        .line_out (tx_line),
        .irq      (tx_irq)
    );

    uart_mf_rx #(.OSR(OSR)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .line_in (rx_line),
        .fmt     (fmt),
        .par_odd (par_odd),
        .rd      (rx_read),
        .word    (rx_data),
        .irq     (rx_irq),
        .fe      (err_frame),
        .pe      (err_parity),
        .oe      (err_overrun)
    );

endmodule

// File: rtl/uart_mf_chk.sv
module uart_mf_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_irq,
    input logic tx_line,
    input logic rx_irq,
    input logic rx_read,
    input logic err_frame,
    input logic err_parity,
    input logic err_overrun
);

    // R3: transmit interrupt lasts one clock
    p_txirq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R3: line rises for the stop bit on the clock after the interrupt
    p_txirq_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> tx_line);

    // R6: receive interrupt lasts one clock
    p_rxirq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R9: overrun appears together with the receive interrupt
    p_overrun_at_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> rx_irq);

    // R10: flags hold until a read
    p_frame_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !rx_read) |=> err_frame);

    p_parity_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !rx_read) |=> err_parity);

endmodule

bind uart_mf uart_mf_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_irq      (tx_irq),
    .tx_line     (tx_line),
    .rx_irq      (rx_irq),
    .rx_read     (rx_read),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun)
);

// File: tb/test_uart_mf.sv
`timescale 1ns/1ps
module test_uart_mf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [2:0] fmt = 3'd2;
    logic       par_odd = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_line, tx_irq;
    logic       rx_line = 1'b1;
    logic       rx_read = 1'b0;
    logic [8:0] rx_data;
    logic       rx_irq, err_frame, err_parity, err_overrun;

    int n = 0;
    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    uart_mf #(.OSR(16)) i_uart_mf (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fmt(fmt), .par_odd(par_odd),
        .tx_data(tx_data), .tx_load(tx_load), .tx_line(tx_line), .tx_irq(tx_irq),
        .rx_line(rx_line), .rx_read(rx_read), .rx_data(rx_data), .rx_irq(rx_irq),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    task automatic step();
        @(negedge clk);
        n++;
        baud_tick = (n % 4 == 0);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nb_of(input int f);
        case (f)
            0, 1:    return 7;
            3:       return 8;
            4:       return 9;
            default: return 8;
        endcase
    endfunction

    function automatic int par_of(input int f);
        return (f == 1 || f == 3) ? 1 : 0;
    endfunction

    function automatic int early_of(input int f);
        return (f == 3 || f == 4) ? 1 : 0;
    endfunction

    task automatic tx_run(input int f, input int d, input int po, input bit second);
        int nb, p, T, m, L, irq_cnt, irq_k, lastv, afterv, bad_i, bad_v, exp_irq;
        int expb[12];
        nb = nb_of(f); p = par_of(f); T = 2 + nb + p;
        m = d & ((1 << nb) - 1);
        expb[0] = 0;
        for (int i = 0; i < nb; i++) expb[1 + i] = (m >> i) & 1;
        if (p == 1) expb[1 + nb] = ($countones(m) & 1) ^ po;
        expb[T - 1] = 1;
        step();
        while (n % 4 != 0) step();
        fmt = 3'(f); par_odd = po[0]; tx_data = 9'(d); tx_load = 1'b1; L = n;
        irq_cnt = 0; irq_k = -1; lastv = -1; afterv = -1; bad_i = -1; bad_v = 0;
        for (int k = 1; k <= 64 * T + 8; k++) begin
            step();
            if (k == 1) tx_load = 1'b0;
            if (second && k == 150) begin tx_data = 9'(d ^ 'h1FF); tx_load = 1'b1; end
            if (second && k == 151) tx_load = 1'b0;
            if (tx_irq) begin irq_cnt++; irq_k = k; lastv = int'(tx_line); end
            if (irq_k >= 0 && k == irq_k + 1) afterv = int'(tx_line);
            if (k >= 34 && (k - 34) % 64 == 0 && (k - 34) / 64 < T)
                if (int'(tx_line) != expb[(k - 34) / 64] && bad_i < 0) begin
                    bad_i = (k - 34) / 64; bad_v = int'(tx_line);
                end
        end
        if (second)     chk(bad_i < 0, "R4 load while busy ignored", bad_i, -1);
        else if (p == 1) chk(bad_i < 0, "R2 frame bits with parity", bad_i, -1);
        else            chk(bad_i < 0, "R1 frame bits", bad_i, -1);
        exp_irq = 1 + 64 * (1 + nb + p);
        chk(irq_cnt == 1 && irq_k == exp_irq, "R3 tx_irq clock", irq_k, exp_irq);
        chk(lastv == expb[T - 2] && afterv == 1, "R3 line around tx_irq", lastv * 2 + afterv,
            expb[T - 2] * 2 + 1);
        L = L; bad_v = bad_v;
    endtask

    task automatic rx_run(input int f, input int d, input int po, input int bp, input int bs,
                          input bit rd, input int exp_oe, input int exp_d);
        int nb, p, T, m, irq_cnt, irq_k, fe_k, pe_k, oe_k, fe_at_irq, exp_bit, pe_bit;
        int expb[12];
        nb = nb_of(f); p = par_of(f); T = 2 + nb + p;
        m = d & ((1 << nb) - 1);
        expb[0] = 0;
        for (int i = 0; i < nb; i++) expb[1 + i] = (m >> i) & 1;
        if (p == 1) expb[1 + nb] = ($countones(m) & 1) ^ po ^ bp;
        expb[T - 1] = 1 - bs;
        fmt = 3'(f); par_odd = po[0];
        irq_cnt = 0; irq_k = -1; fe_k = -1; pe_k = -1; oe_k = -1; fe_at_irq = 0;
        for (int k = 0; k <= 64 * T + 64; k++) begin
            step();
            rx_line = (k < 64 * T) ? expb[k / 64][0] : 1'b1;
            if (rx_irq) begin irq_cnt++; irq_k = k; fe_at_irq = int'(err_frame); end
            if (err_frame && fe_k < 0) fe_k = k;
            if (err_parity && pe_k < 0) pe_k = k;
            if (err_overrun && oe_k < 0) oe_k = k;
        end
        exp_bit = (early_of(f) == 1) ? ((p == 1) ? nb + 1 : nb) : T - 1;
        chk(irq_cnt == 1 && irq_k / 64 == exp_bit && irq_k % 64 >= 20 && irq_k % 64 <= 56,
            "R6 rx_irq slot", irq_k / 64, exp_bit);
        chk(int'(rx_data) == exp_d, "R5 rx_data", int'(rx_data), exp_d);
        chk(int'(err_frame) == bs, "R7 framing flag", int'(err_frame), bs);
        if (bs == 1) chk(fe_k / 64 == T - 1, "R7 framing at stop middle", fe_k / 64, T - 1);
        if (early_of(f) == 1) chk(fe_at_irq == 0, "R7 framing not yet valid at early irq",
                                  fe_at_irq, 0);
        chk(int'(err_parity) == (p & bp), "R8 parity flag", int'(err_parity), p & bp);
        if ((p & bp) == 1) begin
            pe_bit = (f == 3) ? nb + 1 : T - 1;
            chk(pe_k / 64 == pe_bit, "R8 parity flag slot", pe_k / 64, pe_bit);
        end
        chk(int'(err_overrun) == exp_oe, "R9 overrun flag", int'(err_overrun), exp_oe);
        if (exp_oe == 1) chk(oe_k == irq_k, "R9 overrun with irq", oe_k, irq_k);
        if (rd) begin
            step(); rx_read = 1'b1;
            step(); rx_read = 1'b0;
            chk(!err_frame && !err_parity && !err_overrun, "R10 read clears flags",
                int'({err_frame, err_parity, err_overrun}), 0);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int irqs;
        int dv[6];
        dv[0] = 'h000; dv[1] = 'h1FF; dv[2] = 'h0A5; dv[3] = 'h15A; dv[4] = 'h101; dv[5] = 'h080;
        repeat (3) step();
        chk(tx_line == 1'b1 && !tx_irq && !rx_irq && rx_data == 9'd0 &&
            !err_frame && !err_parity && !err_overrun, "R12 reset state",
            int'({tx_line, tx_irq, rx_irq, err_frame, err_parity, err_overrun}), 32);
        rst_n = 1'b1;
        repeat (4) step();
        chk(tx_line == 1'b1 && rx_data == 9'd0, "R12 idle after reset",
            int'(tx_line), 1);

        // transmit sweep: every code incl. reserved, both parity senses
        for (int f = 0; f < 6; f++)
            for (int di = 0; di < 6; di++)
                for (int po = 0; po < 2; po++)
                    tx_run(f, dv[di], po, 1'b0);
        tx_run(4, 'h0F3, 0, 1'b1);
        tx_run(1, 'h055, 1, 1'b1);

        // receive sweep, clean frames
        for (int f = 0; f < 6; f++)
            for (int di = 0; di < 4; di++)
                for (int po = 0; po < 2; po++)
                    rx_run(f, dv[di], po, 0, 0, 1'b1, 0, dv[di] & ((1 << nb_of(f)) - 1));

        // error cases
        rx_run(1, 'h033, 0, 1, 0, 1'b1, 0, 'h033);
        rx_run(3, 'h0C7, 1, 1, 0, 1'b1, 0, 'h0C7);
        rx_run(0, 'h012, 0, 0, 1, 1'b1, 0, 'h012);
        rx_run(3, 'h081, 0, 0, 1, 1'b1, 0, 'h081);
        rx_run(4, 'h1E1, 0, 0, 1, 1'b1, 0, 'h1E1);
        rx_run(1, 'h070, 1, 1, 1, 1'b1, 0, 'h070);
        rx_run(2, 'h0F0, 0, 1, 0, 1'b1, 0, 'h0F0);

        // overrun keeps old word
        rx_run(2, 'h03C, 0, 0, 0, 1'b0, 0, 'h03C);
        rx_run(2, 'h0C3, 0, 0, 0, 1'b1, 1, 'h03C);
        rx_run(4, 'h155, 0, 0, 0, 1'b0, 0, 'h155);
        rx_run(4, 'h0AA, 0, 0, 0, 1'b1, 1, 'h155);

        // sticky framing flag
        rx_run(0, 'h044, 0, 0, 1, 1'b0, 0, 'h044);
        repeat (200) step();
        chk(err_frame == 1'b1, "R10 framing flag held", int'(err_frame), 1);
        rx_read = 1'b1; step(); rx_read = 1'b0; step();
        chk(err_frame == 1'b0, "R10 framing flag cleared by read", int'(err_frame), 0);

        // short low pulse is rejected
        irqs = 0;
        rx_line = 1'b0;
        for (int k = 0; k < 300; k++) begin
            step();
            if (k == 16) rx_line = 1'b1;
            if (rx_irq) irqs++;
        end
        chk(irqs == 0, "R11 glitch gives no rx_irq", irqs, 0);
        rx_run(2, 'h05A, 0, 0, 0, 1'b1, 0, 'h05A);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule